// File: doc/BRIEF.md
# Quad-source saturating narrow-interleave unit

This datapath takes four source vectors of a configurable length, reads every source element as a two's-complement signed integer, and clamps it into an unsigned range one quarter of the source element width. The narrowed values from the four sources are woven together into a single destination vector. Element `e` of source `i` lands in destination element `4*e + i`, so each group of four adjacent destination elements holds one element position taken from each source in source order.

A one-bit size select picks the element widths. Source elements are 32 bits with 8-bit results, or 64 bits with 16-bit results. Every destination element is written on every accepted operation; nothing is masked. Alongside the destination, the unit reports one clamp flag per destination element, which shows where saturation took effect. By default the result is captured one clock after a valid strobe and held until the next one. A parameter selects a purely combinational variant instead.

Top module: `qsn_narrow4`

## Requirements
- R1: With `size_sel` = 0, source elements are 32 bits and results 8 bits. For every e in 0..VLEN/32-1 and i in 0..3, destination byte 4*e+i (bits [8*(4e+i)+7 : 8*(4e+i)]) comes from bits [32e+31:32e] of source i.
- R2: With `size_sel` = 1, source elements are 64 bits and results 16 bits. For every e in 0..VLEN/64-1 and i in 0..3, destination halfword 4*e+i comes from bits [64e+63:64e] of source i.
- R3: A source element whose sign bit is set (a negative value) gives a result of 0.
- R4: A source element greater than the largest unsigned value of the result width (255 or 65535) gives an all-ones result. This includes the most positive source value.
- R5: A source element in the range 0 up to and including that largest value passes through as its low result-width bits, unchanged.
- R6: Bit k of `sat_flags` is 1 exactly when destination element k was clamped by R3 or R4. With `size_sel` = 1, flag bits VLEN/16 and above are 0.
- R7: When `in_valid` is high at a rising edge, `out_valid` is high for the following cycle and `dst` and `sat_flags` show that operation's result. When `in_valid` is low at a rising edge, `out_valid` is low after it.
- R8: While `in_valid` is low, `dst` and `sat_flags` keep their last values whatever the sources and size select do.
- R9: Synchronous active-high `rst` clears `dst`, `sat_flags` and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe; sources and size are captured when high |
| size_sel | input | 1 | 0: 32-to-8 narrowing, 1: 64-to-16 narrowing |
| src0 | input | VLEN | Source vector 0 |
| src1 | input | VLEN | Source vector 1 |
| src2 | input | VLEN | Source vector 2 |
| src3 | input | VLEN | Source vector 3 |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| dst | output | VLEN | Interleaved narrowed destination vector |
| sat_flags | output | VLEN/8 | Per-destination-element clamp flags |

## Verification
Both sizes are driven with vectors whose lanes rotate through the most negative value, minus one, zero, one, the exact unsigned maximum, maximum plus one and the most positive value. Because each lane and source sees a different corner, a wrong clamp boundary and a wrong interleave position show up as different failures. Uniform vectors of one corner value separate the behaviour of the sign test from the overflow test, and tell both apart from the lane mapping. Long runs of pseudo-random full-range values, and of small values near the limits, check that the pass-through bits and the flags stay correct away from the corners. A final sequence changes the inputs while the strobe is low and then applies reset, which shows whether the output truly holds and truly clears.

// File: rtl/qsn_pkg.sv
package qsn_pkg;
  typedef enum logic {SZ_BYTE = 1'b0, SZ_HALF = 1'b1} nsize_e;
  localparam int unsigned LANES = 4;
endpackage

// File: rtl/qsn_sat.sv
module qsn_sat #(
  parameter int unsigned SRC_W = 32,
  parameter int unsigned DST_W = 8
) (
  input  logic [SRC_W-1:0] x,
  output logic [DST_W-1:0] y,
  output logic             clamp
);
  logic neg, over;
  always_comb begin
    neg   = x[SRC_W-1];
    over  = !neg && (|x[SRC_W-2:DST_W]);
    clamp = neg || over;
    if (neg)       y = '0;
    else if (over) y = '1;
    else           y = x[DST_W-1:0];
  end
endmodule

// File: rtl/qsn_bank.sv
module qsn_bank #(
  parameter int unsigned VLEN  = 128,
  parameter int unsigned DST_W = 8
) (
  input  logic [qsn_pkg::LANES-1:0][VLEN-1:0] srcs,
  output logic [VLEN-1:0]                     res,
  output logic [VLEN/DST_W-1:0]               flg
);
  localparam int unsigned SRC_W = qsn_pkg::LANES * DST_W;
  localparam int unsigned NELEM = VLEN / SRC_W;

  for (genvar e = 0; e < NELEM; e++) begin : g_elem
    for (genvar i = 0; i < qsn_pkg::LANES; i++) begin : g_src
      qsn_sat #(.SRC_W(SRC_W), .DST_W(DST_W)) u_sat (
        .x     (srcs[i][e*SRC_W +: SRC_W]),
        .y     (res[(qsn_pkg::LANES*e+i)*DST_W +: DST_W]),
        .clamp (flg[qsn_pkg::LANES*e+i])
      );
    end
  end
endmodule

// File: rtl/qsn_stage.sv
module qsn_stage #(
  parameter int unsigned W          = 8,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] d,
  output logic         out_valid,
  output logic [W-1:0] q
);
  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q         <= '0;
        out_valid <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) q <= d;
      end
    end

    p_valid_lat_r7: assert property (@(posedge clk) disable iff (rst)
      $past(in_valid) |-> out_valid);
    p_valid_drop_r7: assert property (@(posedge clk) disable iff (rst)
      !$past(in_valid) |-> !out_valid);
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(in_valid) && !$past(rst)) |-> $stable(q));
    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (q == '0 && !out_valid));
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst;
    assign q          = d;
    assign out_valid  = in_valid;
  end
endmodule

// File: rtl/qsn_narrow4.sv
module qsn_narrow4 #(
  parameter int unsigned VLEN       = 128,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            size_sel,
  input  logic [VLEN-1:0] src0,
  input  logic [VLEN-1:0] src1,
  input  logic [VLEN-1:0] src2,
  input  logic [VLEN-1:0] src3,
  output logic            out_valid,
  output logic [VLEN-1:0] dst,
  output logic [VLEN/8-1:0] sat_flags
);
  import qsn_pkg::*;

  localparam int unsigned FB = VLEN / 8;
  localparam int unsigned FH = VLEN / 16;
  localparam int unsigned OW = VLEN + FB;

  logic [LANES-1:0][VLEN-1:0] srcs;
  logic [VLEN-1:0] res_b, res_h, res_sel;
  logic [FB-1:0]   flg_b, flg_sel;
  logic [FH-1:0]   flg_h;
  logic [OW-1:0]   q;

  assign srcs = {src3, src2, src1, src0};

  qsn_bank #(.VLEN(VLEN), .DST_W(8)) u_bank_b (
    .srcs (srcs), .res (res_b), .flg (flg_b)
  );
  qsn_bank #(.VLEN(VLEN), .DST_W(16)) u_bank_h (
    .srcs (srcs), .res (res_h), .flg (flg_h)
  );

  always_comb begin
    if (nsize_e'(size_sel) == SZ_HALF) begin
      res_sel = res_h;
      flg_sel = {{(FB-FH){1'b0}}, flg_h};
    end else begin
      res_sel = res_b;
      flg_sel = flg_b;
    end
  end

  qsn_stage #(.W(OW), .REGISTERED(REGISTERED)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .d         ({flg_sel, res_sel}),
    .out_valid (out_valid),
    .q         (q)
  );

  assign dst       = q[VLEN-1:0];
  assign sat_flags = q[OW-1:VLEN];

  if (REGISTERED) begin : g_chk
    p_neg_zero_r3: assert property (@(posedge clk) disable iff (rst)
      ($past(in_valid) && !$past(rst) && !$past(size_sel) && $past(src0[31]))
        |-> (dst[7:0] == 8'h00 && sat_flags[0]));
    p_over_ones_r4: assert property (@(posedge clk) disable iff (rst)
      ($past(in_valid) && !$past(rst) && $past(size_sel) && !$past(src1[63])
        && $past(|src1[62:16])) |-> (dst[31:16] == 16'hFFFF && sat_flags[1]));
    p_half_flags_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(in_valid) && !$past(rst) && $past(size_sel))
        |-> (sat_flags[FB-1:FH] == '0));
  end
endmodule

// File: tb/tb_qsn_narrow4.sv
module tb_qsn_narrow4;
  localparam int unsigned VLEN = 128;
  localparam int unsigned FB   = VLEN / 8;

  logic clk = 1'b0;
  logic rst, in_valid, size_sel;
  logic [VLEN-1:0] src0, src1, src2, src3;
  logic out_valid;
  logic [VLEN-1:0] dst;
  logic [FB-1:0] sat_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;

  always #5 clk = ~clk;

  qsn_narrow4 #(.VLEN(VLEN), .REGISTERED(1'b1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .size_sel(size_sel),
    .src0(src0), .src1(src1), .src2(src2), .src3(src3),
    .out_valid(out_valid), .dst(dst), .sat_flags(sat_flags)
  );

  function automatic logic [63:0] rnd();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed;
  endfunction

  task automatic chk(input string tag, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model straight from the index formula and the clamp rules
  task automatic model(input logic sz, input logic [VLEN-1:0] a0, a1, a2, a3,
                       output logic [VLEN-1:0] ed, output logic [FB-1:0] ef);
    logic [VLEN-1:0] s [4];
    logic signed [63:0] x;
    longint lim;
    int sw, dw;
    s[0] = a0; s[1] = a1; s[2] = a2; s[3] = a3;
    ed = '0; ef = '0;
    dw = sz ? 16 : 8;
    sw = 4 * dw;
    lim = sz ? 65535 : 255;
    for (int e = 0; e < VLEN / sw; e++) begin
      for (int i = 0; i < 4; i++) begin
        if (sz) x = s[i][64*e +: 64];
        else    x = {{32{s[i][32*e+31]}}, s[i][32*e +: 32]};
        if (x < 0) begin
          ef[4*e+i] = 1'b1;
        end else if (x > lim) begin
          ef[4*e+i] = 1'b1;
          for (int b = 0; b < dw; b++) ed[(4*e+i)*dw + b] = 1'b1;
        end else begin
          for (int b = 0; b < dw; b++) ed[(4*e+i)*dw + b] = x[b];
        end
      end
    end
  endtask

  task automatic run_op(input string tag, input logic sz, input logic [VLEN-1:0] a0, a1, a2, a3);
    logic [VLEN-1:0] ed;
    logic [FB-1:0] ef;
    model(sz, a0, a1, a2, a3, ed, ef);
    @(negedge clk);
    size_sel = sz; src0 = a0; src1 = a1; src2 = a2; src3 = a3; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R7 valid"}, VLEN'(out_valid), VLEN'(1));
    chk({tag, sz ? " R2 dst" : " R1 dst"}, dst, ed);
    chk({tag, " R6 flags"}, VLEN'(sat_flags), VLEN'(ef));
  endtask

  function automatic logic [63:0] corner(input logic sz, input int k);
    case (k % 7)
      0: return sz ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
      1: return sz ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
      2: return 64'd0;
      3: return 64'd1;
      4: return sz ? 64'd65535 : 64'd255;
      5: return sz ? 64'd65536 : 64'd256;
      default: return sz ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
    endcase
  endfunction

  function automatic logic [VLEN-1:0] fill(input logic sz, input int base, input int mode);
    logic [VLEN-1:0] v = '0;
    logic [63:0] r;
    int sw = sz ? 64 : 32;
    for (int e = 0; e < VLEN / sw; e++) begin
      r = rnd();
      if (mode == 0) r = corner(sz, base + e);
      else if (mode == 2) r = (sz ? 64'd65535 : 64'd255) + {{54{r[9]}}, r[9:0]};
      else if (mode == 3) r = corner(sz, base);
      if (sz) v[64*e +: 64] = r;
      else    v[32*e +: 32] = r[31:0];
    end
    return v;
  endfunction

  initial begin
    rst = 1'b1; in_valid = 1'b0; size_sel = 1'b0;
    src0 = '0; src1 = '0; src2 = '0; src3 = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset dst", dst, '0);
    chk("R9 reset flags", VLEN'(sat_flags), '0);
    chk("R9 reset valid", VLEN'(out_valid), '0);
    rst = 1'b0;

    for (int sz = 0; sz < 2; sz++) begin
      // R3: all most-negative
      run_op("R3 min", sz[0], fill(sz[0],0,3), fill(sz[0],0,3), fill(sz[0],0,3), fill(sz[0],0,3));
      chk("R3 zero out", dst, '0);
      // R4: all most-positive
      run_op("R4 max", sz[0], fill(sz[0],6,3), fill(sz[0],6,3), fill(sz[0],6,3), fill(sz[0],6,3));
      chk("R4 ones out", dst, '1);
      // R4: maximum plus one
      run_op("R4 max+1", sz[0], fill(sz[0],5,3), fill(sz[0],5,3), fill(sz[0],5,3), fill(sz[0],5,3));
      chk("R4 ones out2", dst, '1);
      // R5: exact max passes unclamped
      run_op("R5 exact", sz[0], fill(sz[0],4,3), fill(sz[0],4,3), fill(sz[0],4,3), fill(sz[0],4,3));
      chk("R5 no flags", VLEN'(sat_flags), '0);
      // R5: zero
      run_op("R5 zero", sz[0], '0, '0, '0, '0);
      // rotating corners over every lane and source
      for (int k = 0; k < 7; k++)
        run_op("corner", sz[0], fill(sz[0],k,0), fill(sz[0],k+1,0), fill(sz[0],k+2,0), fill(sz[0],k+3,0));
      // random full range and near-limit values
      for (int k = 0; k < 200; k++)
        run_op("random", sz[0], fill(sz[0],0,1), fill(sz[0],0,1), fill(sz[0],0,1), fill(sz[0],0,1));
      for (int k = 0; k < 200; k++)
        run_op("nearlim", sz[0], fill(sz[0],0,2), fill(sz[0],0,2), fill(sz[0],0,2), fill(sz[0],0,2));
    end

    // R8: hold while strobe low
    begin
      logic [VLEN-1:0] held_d;
      logic [FB-1:0] held_f;
      run_op("R8 setup", 1'b0, fill(1'b0,0,1), fill(1'b0,0,1), fill(1'b0,0,1), fill(1'b0,0,1));
      held_d = dst; held_f = sat_flags;
      @(negedge clk);
      size_sel = 1'b1; src0 = '1; src1 = '0; src2 = fill(1'b1,0,1); src3 = fill(1'b1,0,1);
      repeat (3) @(negedge clk);
      chk("R8 hold dst", dst, held_d);
      chk("R8 hold flags", VLEN'(sat_flags), VLEN'(held_f));
      chk("R7 valid low", VLEN'(out_valid), '0);
      // R9: reset after activity
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R9 clear dst", dst, '0);
      chk("R9 clear flags", VLEN'(sat_flags), '0);
      chk("R9 clear valid", VLEN'(out_valid), '0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule